// File: doc/BRIEF.md
# Continuous Configuration-Memory CRC Monitor

This block guards a configuration memory against soft errors. In user mode it sweeps the memory through a read port with one cycle of latency, one word per cycle, and folds every bit into a 32-bit CRC. Once the last word has been absorbed, it shifts the 32-bit reference value through the same CRC. If the memory is intact and the reference is right, the remainder is zero and the error flag stays low. Any nonzero remainder raises the flag. The sweep then starts over and repeats until reset.

The reference register is loaded once, by the configuration loader, before user mode begins. While in user mode, software can read it back through a small register port and can also overwrite it. Writing a wrong value deliberately provokes a detected error. Writing the saved value back restores normal checking, and the memory does not have to be reloaded. Each accepted write restarts the sweep, so no pass ever combines two reference values.

Top module: `cfg_crc_scrubber`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `crc_error`, `pass_end`, `mem_addr` and the reference register to zero.
- R2: In user mode, `mem_addr` runs 0, 1, ..., DEPTH-1 with one step per cycle and then stays at 0 for two more cycles. `pass_end` pulses for one cycle every DEPTH+2 cycles, and it coincides with the cycle in which `mem_addr` is 0 again at the start of the next sweep.
- R3: The CRC uses the generator 0x04C11DB7. It is computed MSB-first without bit reflection, starts from 0xFFFFFFFF, and feeds each word MSB first. After the last word, the 32 reference bits are fed MSB first, and no final XOR is applied. When the reference equals the CRC of the memory contents, the remainder is zero and `crc_error` is 0 after `pass_end`.
- R4: If any memory bit is flipped, or any reference bit differs from the correct value, `crc_error` is 1 from the end of the first full pass after the change.
- R5: `crc_error` changes only in the cycle where `pass_end` is 1, and holds its value in all other cycles.
- R6: In user mode, a write on the register port replaces the reference on the next edge, and `reg_rd_data` always shows the current reference.
- R7: Register-port writes have no effect when `user_mode` is 0. Configuration captures (`cfg_ref_valid`) take effect only when `user_mode` is 0 and have no effect in user mode.
- R8: An accepted register write restarts the sweep. On the next cycle `mem_addr` is 0, on the one after that it is 1, and no `pass_end` is produced for the interrupted pass.
- R9: When `user_mode` is 0, no scanning takes place. `mem_addr` stays 0, `pass_end` stays 0 and `crc_error` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset / reconfigure |
| user_mode | input | 1 | 1 = device in user mode (scanning, register writes allowed) |
| mem_addr | output | ADDR_W | Configuration memory read address |
| mem_rdata | input | DATA_W | Read data, valid one cycle after its address |
| cfg_ref_valid | input | 1 | Configuration loader capture strobe for the reference |
| cfg_ref_data | input | 32 | Reference value from the configuration loader |
| reg_wr_en | input | 1 | Register-port write strobe for the reference |
| reg_wr_data | input | 32 | Register-port write data |
| reg_rd_data | output | 32 | Current reference value |
| crc_error | output | 1 | 1 = last completed pass left a nonzero remainder |
| pass_end | output | 1 | One-cycle pulse when a pass result is latched |

## Verification
The bench flips single bits at the first and last words, corrupts a whole word, and damages the reference at its LSB and MSB. It expects each of these to raise the flag, and expects the flag to clear once the right value is written back. A design that reversed the bit order, skipped the drain cycle or mishandled the fold would still report an error when the memory is clean. The bench also writes the reference in the middle of a sweep and expects the address to return to 0 at once; a design that mixed reference values would give a false result. Finally, it checks that writes outside user mode, and configuration captures inside it, leave the readback unchanged. It also checks that a memory corruption made mid-pass does not change the flag before a pass boundary.

// File: rtl/cfg_crc_pkg.sv
// Package: shared constants and types for the configuration CRC monitor.
// Assumes a 32-bit MSB-first CRC with no reflection.
package cfg_crc_pkg;
    localparam int          CRC_W    = 32;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FOLD  = 2'd3
    } scan_state_t;
endpackage

// File: rtl/crc_stepper.sv
// crc_stepper: combinational advance of the CRC register over IN_W input
// bits, MSB first, using the package generator. It assumes the caller
// registers the result. It holds no state.
module crc_stepper
    import cfg_crc_pkg::*;
#(
    parameter int IN_W = 8
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic [IN_W-1:0]  din,
    output logic [CRC_W-1:0] crc_out
);
    // Shift one bit at a time, feeding back the generator on a set MSB.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = crc_in;
        for (int i = IN_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ din[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ CRC_POLY;
            end
        end
        crc_out = acc;
    end
endmodule

// File: rtl/scan_sequencer.sv
// scan_sequencer: walks the memory address space, one word per cycle, then
// spends one drain cycle for the last read to return and one fold cycle in
// which the reference is applied. It assumes a one-cycle read latency.
// Leaving user mode parks it at address 0, and a restart begins a new sweep.
module scan_sequencer
    import cfg_crc_pkg::*;
#(
    parameter int DEPTH  = 12,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    output logic [ADDR_W-1:0] addr,
    output logic              data_vld,
    output logic              fold,
    output logic              clr_crc
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    scan_state_t       state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              dv_q;

    // Advance the sweep state, address and read-valid pipeline bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            dv_q    <= 1'b0;
        end else if (restart) begin
            state_q <= ST_SCAN;
            addr_q  <= '0;
            dv_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    state_q <= ST_SCAN;
                    addr_q  <= '0;
                    dv_q    <= 1'b0;
                end
                ST_SCAN: begin
                    dv_q <= 1'b1;
                    if (addr_q == LAST_ADDR) begin
                        state_q <= ST_DRAIN;
                        addr_q  <= '0;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    dv_q    <= 1'b0;
                    state_q <= ST_FOLD;
                end
                default: begin
                    state_q <= ST_SCAN;
                    addr_q  <= '0;
                    dv_q    <= 1'b0;
                end
            endcase
        end
    end

    // Decode outputs; a restart or leaving user mode cancels the fold.
    always_comb begin
        addr     = addr_q;
        data_vld = dv_q;
        fold     = (state_q == ST_FOLD) && run && !restart;
        clr_crc  = fold || restart || !run || (state_q == ST_IDLE);
    end

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(addr_q) < DEPTH) else $error("address out of range"); // R2
    AST_IDLE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (addr_q == '0 && state_q == ST_IDLE)) else $error("scan while not in user mode"); // R9
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && restart) |=> (addr_q == '0 && state_q == ST_SCAN)) else $error("restart ignored"); // R8
    AST_FOLD_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        fold |-> $past(state_q) == ST_DRAIN) else $error("fold without drain"); // R2
endmodule

// File: rtl/ref_holder.sv
// ref_holder: the 32-bit reference register. The configuration loader
// captures it outside user mode, and the register port may overwrite it only
// in user mode. An accepted port write raises restart for the sequencer.
module ref_holder
    import cfg_crc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             user_mode,
    input  logic             cfg_vld,
    input  logic [CRC_W-1:0] cfg_data,
    input  logic             wr_en,
    input  logic [CRC_W-1:0] wr_data,
    output logic [CRC_W-1:0] ref_q,
    output logic             restart
);
    logic cfg_take;
    logic wr_take;

    // Qualify each write source by the device mode.
    always_comb begin
        cfg_take = cfg_vld && !user_mode;
        wr_take  = wr_en && user_mode;
        restart  = wr_take;
    end

    // Hold the reference; the port write wins when both are qualified.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q <= '0;
        end else if (wr_take) begin
            ref_q <= wr_data;
        end else if (cfg_take) begin
            ref_q <= cfg_data;
        end
    end

    AST_REF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode && !cfg_vld) |=> $stable(ref_q)) else $error("ref changed while locked"); // R7
    AST_CFG_IN_USER: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && !wr_en) |=> $stable(ref_q)) else $error("capture in user mode"); // R7
    AST_WR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode && wr_en) |=> ref_q == $past(wr_data)) else $error("write lost"); // R6
endmodule

// File: rtl/cfg_crc_scrubber.sv
// cfg_crc_scrubber: top of the continuous configuration-memory CRC monitor.
// It assumes a synchronous memory read port with one cycle of latency.
// Each pass absorbs DEPTH words, folds in the reference and latches
// crc_error from the remainder, so a zero remainder means intact memory.
module cfg_crc_scrubber
    import cfg_crc_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 12,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              user_mode,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              cfg_ref_valid,
    input  logic [CRC_W-1:0]  cfg_ref_data,
    input  logic              reg_wr_en,
    input  logic [CRC_W-1:0]  reg_wr_data,
    output logic [CRC_W-1:0]  reg_rd_data,
    output logic              crc_error,
    output logic              pass_end
);
    logic [CRC_W-1:0] ref_val;
    logic             restart;
    logic             data_vld;
    logic             fold;
    logic             clr_crc;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_data_nxt;
    logic [CRC_W-1:0] residue;
    logic             err_q;
    logic             end_q;

    ref_holder u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .user_mode (user_mode),
        .cfg_vld   (cfg_ref_valid),
        .cfg_data  (cfg_ref_data),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .ref_q     (ref_val),
        .restart   (restart)
    );

    scan_sequencer #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (user_mode),
        .restart  (restart),
        .addr     (mem_addr),
        .data_vld (data_vld),
        .fold     (fold),
        .clr_crc  (clr_crc)
    );

    crc_stepper #(.IN_W(DATA_W)) u_data_step (
        .crc_in  (crc_q),
        .din     (mem_rdata),
        .crc_out (crc_data_nxt)
    );

    crc_stepper #(.IN_W(CRC_W)) u_ref_fold (
        .crc_in  (crc_q),
        .din     (ref_val),
        .crc_out (residue)
    );

    // Running CRC: reseeded at pass boundaries, advanced on returned data.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_crc) begin
            crc_q <= CRC_SEED;
        end else if (data_vld) begin
            crc_q <= crc_data_nxt;
        end
    end

    // Latch the pass verdict and the pass-end strobe at the fold cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
            end_q <= 1'b0;
        end else begin
            end_q <= fold;
            if (fold) begin
                err_q <= (residue != '0);
            end
        end
    end

    assign reg_rd_data = ref_val;
    assign crc_error   = err_q;
    assign pass_end    = end_q;

    AST_ERR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(err_q) |-> end_q) else $error("flag moved mid-pass"); // R5
    AST_NO_END_OFFLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (!user_mode && !$past(user_mode)) |-> !end_q) else $error("pass end while offline"); // R9
    AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        end_q |=> !end_q) else $error("pass end longer than a cycle"); // R2
endmodule

// File: tb/tb_cfg_crc_scrubber.sv
module tb_cfg_crc_scrubber;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 12;
    localparam int ADDR_W = $clog2(DEPTH);

    typedef struct packed {
        logic [3:0]  idx;
        logic [7:0]  mask;
        logic [31:0] delta;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    // idx/mask: memory corruption; delta: XOR applied to the good reference.
    localparam vec_t VEC [8] = '{
        '{4'd0,  8'h00, 32'h0000_0000, 1'b0, 4'd3},
        '{4'd0,  8'h01, 32'h0000_0000, 1'b1, 4'd4},
        '{4'd11, 8'h80, 32'h0000_0000, 1'b1, 4'd4},
        '{4'd0,  8'h00, 32'h0000_0001, 1'b1, 4'd4},
        '{4'd0,  8'h00, 32'h8000_0000, 1'b1, 4'd4},
        '{4'd5,  8'hFF, 32'h0000_0000, 1'b1, 4'd4},
        '{4'd3,  8'h00, 32'h0000_0000, 1'b0, 4'd3},
        '{4'd7,  8'h10, 32'h0000_0000, 1'b1, 4'd4}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              user_mode = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic              cfg_ref_valid = 1'b0;
    logic [31:0]       cfg_ref_data = '0;
    logic              reg_wr_en = 1'b0;
    logic [31:0]       reg_wr_data = '0;
    logic [31:0]       reg_rd_data;
    logic              crc_error;
    logic              pass_end;

    logic [DATA_W-1:0] mem [DEPTH];
    int n_chk  = 0;
    int n_fail = 0;
    logic done = 1'b0;
    logic [31:0] golden;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) mem_rdata <= mem[mem_addr];

    cfg_crc_scrubber #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cfg_ref_valid(cfg_ref_valid), .cfg_ref_data(cfg_ref_data),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
        .reg_rd_data(reg_rd_data), .crc_error(crc_error), .pass_end(pass_end)
    );

    // Reference model from R3: MSB-first, generator 0x04C11DB7.
    function automatic logic [31:0] crc_bits(input logic [31:0] c, input logic [31:0] d, input int n);
        logic [31:0] r = c;
        for (int i = n - 1; i >= 0; i--) begin
            if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ 32'h04C1_1DB7;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [31:0] mem_crc();
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int k = 0; k < DEPTH; k++) r = crc_bits(r, {24'h0, mem[k]}, 8);
        return r;
    endfunction

    task automatic base_fill();
        for (int k = 0; k < DEPTH; k++) mem[k] = DATA_W'(8'h3C ^ (k * 37));
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_pass();
        int lim = 0;
        while (pass_end !== 1'b1 && lim < 200) begin
            tick();
            lim++;
        end
        if (lim >= 200) chk("pass_end timeout", 0, 1);
    endtask

    task automatic reg_write(input logic [31:0] v);
        reg_wr_en = 1'b1;
        reg_wr_data = v;
        tick();
        reg_wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        base_fill();
        golden = mem_crc();
        tick(); tick();
        // R1: reset state
        chk("R1 crc_error", {31'h0, crc_error}, 0);
        chk("R1 pass_end", {31'h0, pass_end}, 0);
        chk("R1 ref", reg_rd_data, 0);
        chk("R1 addr", 32'(mem_addr), 0);
        rst_n = 1'b1;
        // R7: configuration capture outside user mode
        cfg_ref_valid = 1'b1; cfg_ref_data = golden;
        tick();
        cfg_ref_valid = 1'b0;
        chk("R7 cfg capture", reg_rd_data, golden);
        // R7: port write outside user mode ignored
        reg_write(32'hDEAD_BEEF);
        chk("R7 write outside user mode", reg_rd_data, golden);
        user_mode = 1'b1;
        tick();
        // R3: clean memory, correct reference
        wait_pass();
        chk("R3 clean pass", {31'h0, crc_error}, 0);
        // R2: address sweep and pass period
        for (int k = 0; k < DEPTH; k++) begin
            chk("R2 addr", 32'(mem_addr), k);
            tick();
        end
        chk("R2 drain addr", 32'(mem_addr), 0);
        tick();
        chk("R2 no early end", {31'h0, pass_end}, 0);
        tick();
        chk("R2 period", {31'h0, pass_end}, 1);
        // Vector table: memory flips and reference damage
        foreach (VEC[i]) begin
            base_fill();
            mem[VEC[i].idx] = mem[VEC[i].idx] ^ VEC[i].mask;
            reg_write(golden ^ VEC[i].delta);
            chk($sformatf("R6 readback v%0d", i), reg_rd_data, golden ^ VEC[i].delta);
            wait_pass();
            chk($sformatf("R%0d vector %0d", VEC[i].req, i), {31'h0, crc_error}, {31'h0, VEC[i].exp_err});
        end
        // Restore: write back correct value
        base_fill();
        reg_write(golden);
        wait_pass();
        chk("R4 restore clears", {31'h0, crc_error}, 0);
        // R8: restart mid-sweep
        while (mem_addr != ADDR_W'(5)) tick();
        reg_write(golden);
        chk("R8 addr restart", 32'(mem_addr), 0);
        tick();
        chk("R8 addr next", 32'(mem_addr), 1);
        // R5: mid-pass corruption leaves flag until a pass boundary
        begin
            logic bad = 1'b0;
            logic prev;
            int seen = 0;
            mem[2] = mem[2] ^ 8'h04;
            prev = crc_error;
            while (seen < 2) begin
                tick();
                if (pass_end) seen++;
                else if (crc_error !== prev) bad = 1'b1;
                prev = crc_error;
            end
            chk("R5 flag held between passes", {31'h0, bad}, 0);
            chk("R4 corruption detected", {31'h0, crc_error}, 1);
        end
        // R7: capture in user mode ignored
        cfg_ref_valid = 1'b1; cfg_ref_data = 32'h1234_5678;
        tick();
        cfg_ref_valid = 1'b0;
        chk("R7 capture in user mode", reg_rd_data, golden);
        // R9: offline parks the scan
        user_mode = 1'b0;
        begin
            logic moved = 1'b0;
            tick();
            for (int c = 0; c < 30; c++) begin
                tick();
                if (mem_addr != '0 || pass_end || crc_error !== 1'b1) moved = 1'b1;
            end
            chk("R9 idle outside user mode", {31'h0, moved}, 0);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule